// File: doc/BRIEF.md
# Multi-Select Static RAM with Shared Bus

This block is a clocked model of a small static memory, 128 words of 8 bits, meant to sit directly on a processor's bidirectional data bus. One set of eight bus lines carries both the data being written and the data being read. The processor steers the memory with two active-low strobes, one for read and one for write. Five chip-select inputs, some active high and some active low, allow several such memories to share an address space without any glue logic.

The chip selects and strobes are decoded into one of four modes. In read, the memory drives the addressed word onto the bus. In write, it samples the bus into the addressed word. In standby, it neither drives nor stores. When it is not selected, the strobes have no effect. The bus is driven only during a selected read. A 2-bit status output shows the mode currently decoded.

The read path is modelled with one clock of latency. Read data stays on the bus until the read strobe rises, the device is deselected, or the address moves. The bus is released in the same cycle as any of these events. A drive-enable output mirrors the tristate control so that the bus owner is visible at the ports.

Top module: `msel_sram`

## Requirements
- R1: The device is selected only when cs_i[0] and cs_i[3] are high and cs_i[1], cs_i[2] and cs_i[4] are low. Any one select at its inactive level gives the not-selected mode.
- R2: mode_o shows the decoded mode combinationally from the current inputs: 2'b00 not selected, 2'b01 standby (selected, both strobes high), 2'b10 write (selected, rd_n_i high, wr_n_i low), 2'b11 read (selected, rd_n_i low, wr_n_i ignored).
- R3: In read mode, once one rising clock edge has passed with the mode and address unchanged, the bus carries the stored word at addr_i. A low wr_n_i during a read neither changes this nor writes memory.
- R4: In write mode, the bus value is stored into the word at addr_i at the rising clock edge. A later read of that address returns the new value.
- R5: In write mode the block does not drive the bus.
- R6: In standby the block does not drive the bus, and no word changes even while the bus carries data.
- R7: When not selected, the block does not drive the bus and no word changes, for every level of both strobes.
- R8: Bus drive ends in the same cycle that rd_n_i rises, that the device is deselected, or that addr_i changes. After an address change in read mode, the new word is driven one edge later.
- R9: bus_drive_o is high exactly when the block drives data_io.
- R10: All 128 words are independent: writing every address with a distinct value and reading them all back returns each value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset of control state (memory is not reset) |
| addr_i | input | 7 | Word address |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| cs_i | input | 5 | Chip selects; bits 0 and 3 active high, bits 1, 2 and 4 active low |
| data_io | inout | 8 | Shared bidirectional data bus |
| mode_o | output | 2 | Decoded mode |
| bus_drive_o | output | 1 | High while the block drives data_io |

## Verification
The hardest case to reach is a write strobe that arrives while the chip-select pattern is one bit away from a valid selection. Such a write must leave memory untouched, and that can only be seen through a later read. The bench first fills every word with a value computed from its address. It then tries a write with an inverted value under each of the 31 non-selecting chip-select patterns, each aimed at its own address, and then in standby. A full read-back sweep shows that no word changed. Bus release on a strobe edge, on deselection and on an address move is checked by sampling within the cycle of the change and again after the next edge.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned NUM_CS = 5;
  // polarity of each select: 1 = active high
  localparam logic [NUM_CS-1:0] CS_ACTIVE_HIGH = 5'b01001;

  typedef enum logic [1:0] {
    MODE_NOSEL = 2'b00,
    MODE_STBY  = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_READ  = 2'b11
  } mode_t;

  function automatic logic cs_bit_true(input logic level, input logic act_high);
    return act_high ? level : ~level;
  endfunction

  function automatic mode_t decode_mode(input logic sel, input logic rd_n, input logic wr_n);
    if (!sel)       return MODE_NOSEL;
    else if (!rd_n) return MODE_READ;
    else if (!wr_n) return MODE_WRITE;
    else            return MODE_STBY;
  endfunction
endpackage

// File: rtl/sram_sel_decode.sv
module sram_sel_decode #(
  parameter int unsigned NCS = 5,
  parameter logic [NCS-1:0] ACT_HIGH = '1
) (
  input  logic [NCS-1:0] cs_i,
  output logic           sel_o
);
  logic [NCS-1:0] hit;

  for (genvar i = 0; i < NCS; i++) begin : g_hit
    assign hit[i] = sram_pkg::cs_bit_true(cs_i[i], ACT_HIGH[i]);
  end

  assign sel_o = &hit;
endmodule

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_pkg::*;
(
  input  logic  sel_i,
  input  logic  rd_n_i,
  input  logic  wr_n_i,
  output mode_t mode_o,
  output logic  rd_en_o,
  output logic  wr_en_o
);
  assign mode_o  = decode_mode(sel_i, rd_n_i, wr_n_i);
  assign rd_en_o = (mode_o == MODE_READ);
  assign wr_en_o = (mode_o == MODE_WRITE);
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int unsigned WORDS = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (re_i) rdata_q <= mem[addr_i];
  end

  assign rdata_o = rdata_q;

  // R4
  wr_then_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && $past(we_i) && $past(addr_i) == addr_i) |=> (rdata_o == $past(wdata_i, 2)));
endmodule

// File: rtl/msel_sram.sv
module msel_sram
  import sram_pkg::*;
#(
  parameter int unsigned WORDS = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [NUM_CS-1:0] cs_i,
  inout  wire  [DW-1:0]     data_io,
  output logic [1:0]        mode_o,
  output logic              bus_drive_o
);
  logic          sel;
  mode_t         mode;
  logic          rd_en, wr_en;
  logic [DW-1:0] rdata;
  logic          rd_valid_q;
  logic [AW-1:0] rd_addr_q;
  logic          drive_en;

  sram_sel_decode #(.NCS(NUM_CS), .ACT_HIGH(CS_ACTIVE_HIGH)) u_sel (
    .cs_i (cs_i),
    .sel_o(sel)
  );

  sram_mode_decode u_mode (
    .sel_i  (sel),
    .rd_n_i (rd_n_i),
    .wr_n_i (wr_n_i),
    .mode_o (mode),
    .rd_en_o(rd_en),
    .wr_en_o(wr_en)
  );

  sram_array #(.WORDS(WORDS), .DW(DW)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en),
    .re_i   (rd_en),
    .addr_i (addr_i),
    .wdata_i(data_io),
    .rdata_o(rdata)
  );

  // read data becomes valid one edge after a read with a steady address
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_addr_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      rd_addr_q  <= addr_i;
    end
  end

  assign drive_en    = rd_en && rd_valid_q && (rd_addr_q == addr_i);
  assign data_io     = drive_en ? rdata : {DW{1'bz}};
  assign bus_drive_o = drive_en;
  assign mode_o      = mode;

  // R1
  cs_desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i[1] |-> (mode_o == 2'b00));
  // R8
  rd_rise_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_n_i) |-> !bus_drive_o);
  // R8
  addr_move_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_i) |-> !bus_drive_o);
  // R5
  drive_only_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_drive_o |-> (mode_o == 2'b11 && $past(mode_o) == 2'b11));
endmodule

// File: tb/msel_sram_tb.sv
`timescale 1ns/100ps
module msel_sram_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] addr = '0;
  logic       rd_n = 1'b1, wr_n = 1'b1;
  logic [4:0] cs = 5'b00000;
  logic       tb_en = 1'b0;
  logic [7:0] tb_val = '0;
  wire  [7:0] bus;
  logic [1:0] mode;
  logic       drv;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [4:0] CS_ON = 5'b01001;

  always #2.5 clk = ~clk;
  assign bus = tb_en ? tb_val : 8'bz;

  msel_sram dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .cs_i(cs), .data_io(bus), .mode_o(mode), .bus_drive_o(drv)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic selected(input logic [4:0] c);
    return c[0] & ~c[1] & ~c[2] & c[3] & ~c[4];
  endfunction

  function automatic logic [1:0] exp_mode(input logic [4:0] c, input logic r, input logic w);
    if (!selected(c)) return 2'b00;
    if (!r) return 2'b11;
    if (!w) return 2'b10;
    return 2'b01;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cs = 5'b00000; rd_n = 1'b1; wr_n = 1'b1; tb_en = 1'b0;
  endtask

  task automatic write_word(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = CS_ON; addr = a; rd_n = 1'b1; wr_n = 1'b0; tb_en = 1'b1; tb_val = d;
    #0.5 chk("R5 write drive", drv, 1'b0);
  endtask

  task automatic read_word(input logic [6:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    tb_en = 1'b0; cs = CS_ON; addr = a; rd_n = 1'b0; wr_n = 1'b1;
    @(negedge clk);
    #0.5;
    chk(req, drv, 1'b1);
    chk(req, bus, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset mode", mode, 2'b00);
    chk("R9 reset drive", drv, 1'b0);
    rst_n = 1'b1;

    // R1 R2 R5 R6 R7: sweep every select pattern and strobe pair
    for (int c = 0; c < 32; c++) begin
      for (int s = 0; s < 4; s++) begin
        idle();
        @(negedge clk);
        cs = 5'(c); rd_n = s[0]; wr_n = s[1]; addr = 7'd0; tb_en = s[0]; tb_val = 8'h5a;
        #0.5;
        chk("R1/R2 mode", mode, exp_mode(5'(c), s[0], s[1]));
        chk("R9 drive before edge", drv, 1'b0);
        @(negedge clk);
        #0.5;
        chk("R3/R5/R6/R7 drive", drv, exp_mode(5'(c), s[0], s[1]) == 2'b11);
      end
    end
    idle();

    // R10 R4: fill then read back all words
    for (int a = 0; a < 128; a++) write_word(7'(a), pat(a));
    for (int a = 0; a < 128; a++) read_word(7'(a), pat(a), "R10 readback");

    // R7: writes under each non-selecting pattern must not land
    for (int c = 0; c < 32; c++) begin
      if (5'(c) != CS_ON) begin
        @(negedge clk);
        cs = 5'(c); addr = 7'(c); rd_n = 1'b1; wr_n = 1'b0; tb_en = 1'b1; tb_val = ~pat(c);
        #0.5 chk("R7 desel drive", drv, 1'b0);
      end
    end
    // R6: standby with data on bus
    for (int a = 40; a < 48; a++) begin
      @(negedge clk);
      cs = CS_ON; addr = 7'(a); rd_n = 1'b1; wr_n = 1'b1; tb_en = 1'b1; tb_val = ~pat(a);
      #0.5 chk("R6 stby mode", mode, 2'b01);
    end
    idle();
    for (int a = 0; a < 48; a++) read_word(7'(a), pat(a), "R6/R7 unchanged");

    // R3: read with write strobe low returns data and writes nothing
    @(negedge clk);
    cs = CS_ON; addr = 7'd60; rd_n = 1'b0; wr_n = 1'b0; tb_en = 1'b0;
    @(negedge clk);
    #0.5 chk("R3 rd with wr low", bus, pat(60));
    idle();
    read_word(7'd60, pat(60), "R3 no write");

    // R4: overwrite then read
    write_word(7'd99, 8'hc3);
    read_word(7'd99, 8'hc3, "R4 new value");

    // R8: release on read strobe rise
    read_word(7'd10, pat(10), "R8 setup");
    @(negedge clk); rd_n = 1'b1;
    #0.5 chk("R8 rd rise", drv, 1'b0);
    // R8: release on deselect
    read_word(7'd11, pat(11), "R8 setup");
    @(negedge clk); cs = CS_ON | 5'b00100;
    #0.5 chk("R8 deselect", drv, 1'b0);
    // R8: release on address move, new word after one edge
    read_word(7'd12, pat(12), "R8 setup");
    @(negedge clk); addr = 7'd13;
    #0.5 chk("R8 addr move", drv, 1'b0);
    @(negedge clk);
    #0.5;
    chk("R8 new drive", drv, 1'b1);
    chk("R8 new word", bus, pat(13));
    idle();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule